// File: doc/BRIEF.md
# Two-Word Circular Interrupt Logger

This block keeps a running history of interrupt events in a fixed window of a shared, word-addressed RAM. Each event arrives as a one-cycle strobe with two 16-bit words. One is an identification word naming the kind of interrupt. The other is a command-address word naming the command that raised it. The block writes the pair into two adjacent RAM words through a plain synchronous write port. A RAM arbiter may hold that port back with a single grant input.

The window is used as a ring of entries. A readable pointer always shows the RAM address where the next entry will start. After the last slot the pointer returns to the window base, so the newest event overwrites the oldest one. A one-deep holding register absorbs an event that arrives while the previous pair is still being written. Any further event in that state is dropped and raises a sticky overflow flag.

Top module: `irq_ring_logger`

## Requirements
- R1: After reset, `log_ptr` equals `BASE_ADDR`, `mem_we` is 0 and `overflow` is 0.
- R2: An accepted event is stored as two RAM writes on two granted cycles. The identification word goes to address `log_ptr` and the command-address word to `log_ptr`+1. With grant held high, the first write happens in the cycle after the strobe and the second write in the cycle after that.
- R3: `log_ptr` keeps its value during both writes of an entry. It advances by 2 only at the clock edge that completes the second write.
- R4: With `ENTRIES`=16, the window is 32 words long and holds one entry every 2 words. The slot after `BASE_ADDR`+30 is `BASE_ADDR`. After 16 completed entries, `log_ptr` is back where it started, and the next entry overwrites the oldest slot.
- R5: While `mem_grant` is 0, `mem_we` stays 0 and `log_ptr` does not move. A pending word is written once grant returns, including when grant is withdrawn between the two words of an entry.
- R6: A strobe that arrives while an entry is still unfinished is held. That event is written as the next entry, directly after the current one, with its own words unchanged.
- R7: A strobe that arrives while an entry is unfinished and another event is already held is discarded and never written. It sets `overflow`, which then stays 1 until reset.
- R8: A strobe in the cycle that completes the second write of an entry counts as arriving after that entry. It never sets `overflow`, even when an event is already held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | 1 | One-cycle pulse per interrupt event |
| evt_id | input | 16 | Identification word of the event |
| evt_cmd | input | 16 | Command-address word of the event |
| mem_grant | input | 1 | RAM arbiter grant; 0 stalls writes |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 15 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| log_ptr | output | 15 | Address of the next entry to be written |
| overflow | output | 1 | Sticky flag: an event was dropped |

## Verification
The logger is tried with these input patterns:
- **Isolated events on a free port.** These fix the word order, the address pairing and the moment the pointer moves.
- **A run of sixteen events.** This shows the wrap back to the base and the overwrite of the oldest slot.
- **A withdrawn grant, before an entry and between its two words.** This separates a stalled write from a lost one.
- **Strobes on consecutive cycles.** These tell the three overlap outcomes apart: held, dropped with the flag set, or accepted in the completing cycle without overflow.

// File: rtl/irq_log_pkg.sv
`timescale 1ns/1ps
package irq_log_pkg;

  localparam int WORD_W = 16;

  typedef struct packed {
    logic [WORD_W-1:0] id;
    logic [WORD_W-1:0] cmd;
  } irq_evt_t;

  // Start address of the slot that follows 'ptr' in a ring of 'entries' two-word slots.
  function automatic int unsigned ring_next(int unsigned ptr, int unsigned base,
                                            int unsigned entries);
    int unsigned off;
    off = (ptr - base + 2) % (2 * entries);
    return base + off;
  endfunction

  // True when 'ptr' is a legal slot start inside the ring.
  function automatic bit ring_legal(int unsigned ptr, int unsigned base,
                                    int unsigned entries);
    return (ptr >= base) && (ptr < base + 2 * entries) && (((ptr - base) % 2) == 0);
  endfunction

endpackage

// File: rtl/irq_log_capture.sv
`timescale 1ns/1ps
module irq_log_capture
  import irq_log_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     evt_strobe,
  input  irq_evt_t evt_in,
  input  logic     slot_done,
  output logic     cur_valid,
  output irq_evt_t cur_evt,
  output logic     pend_valid,
  output logic     overflow
);

  irq_evt_t pend_evt;
  logic     slot_free;
  logic     drop_evt;

  assign slot_free = !cur_valid || slot_done;
  assign drop_evt  = evt_strobe && !slot_free && pend_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_valid  <= 1'b0;
      cur_evt    <= '0;
      pend_valid <= 1'b0;
      pend_evt   <= '0;
      overflow   <= 1'b0;
    end else begin
      if (slot_free) begin
        if (pend_valid) begin
          cur_valid  <= 1'b1;
          cur_evt    <= pend_evt;
          pend_valid <= evt_strobe;
          if (evt_strobe) pend_evt <= evt_in;
        end else begin
          cur_valid <= evt_strobe;
          if (evt_strobe) cur_evt <= evt_in;
        end
      end else if (evt_strobe && !pend_valid) begin
        pend_valid <= 1'b1;
        pend_evt   <= evt_in;
      end
      if (drop_evt) overflow <= 1'b1;
    end
  end

  // R6
  pend_needs_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> cur_valid);

  // R6
  pend_promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_done && pend_valid) |=> (cur_valid && cur_evt == $past(pend_evt)));

  // R7
  drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overflow);

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R8
  done_cycle_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_done && !overflow) |=> !overflow);

endmodule

// File: rtl/irq_log_writer.sv
`timescale 1ns/1ps
module irq_log_writer
  import irq_log_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int BASE_ADDR = 'h0400,
  parameter int ENTRIES   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur_valid,
  input  irq_evt_t          cur_evt,
  input  logic              mem_grant,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] log_ptr,
  output logic              slot_done
);

  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

  logic second_word;
  logic word_fire;

  assign word_fire = cur_valid && mem_grant;
  assign slot_done = word_fire && second_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second_word <= 1'b0;
      log_ptr     <= BASE_V;
    end else if (word_fire) begin
      second_word <= !second_word;
      if (second_word)
        log_ptr <= ADDR_W'(ring_next(32'(log_ptr), BASE_ADDR, ENTRIES));
    end
  end

  assign mem_we    = word_fire;
  assign mem_addr  = log_ptr + ADDR_W'(second_word);
  assign mem_wdata = second_word ? cur_evt.cmd : cur_evt.id;

  // R5
  we_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_grant);

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_done |=> $stable(log_ptr));

  // R3
  ptr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done |=> (log_ptr != $past(log_ptr)));

  // R4
  ptr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_legal(32'(log_ptr), BASE_ADDR, ENTRIES));

  // R2
  second_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !second_word) |=> (!mem_grant || mem_we));

endmodule

// File: rtl/irq_ring_logger.sv
`timescale 1ns/1ps
module irq_ring_logger
  import irq_log_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int BASE_ADDR = 'h0400,
  parameter int ENTRIES   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_strobe,
  input  logic [WORD_W-1:0] evt_id,
  input  logic [WORD_W-1:0] evt_cmd,
  input  logic              mem_grant,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] log_ptr,
  output logic              overflow
);

  irq_evt_t evt_in;
  irq_evt_t cur_evt;
  logic     cur_valid;
  logic     pend_valid;
  logic     slot_done;

  assign evt_in.id  = evt_id;
  assign evt_in.cmd = evt_cmd;

  irq_log_capture u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_strobe (evt_strobe),
    .evt_in     (evt_in),
    .slot_done  (slot_done),
    .cur_valid  (cur_valid),
    .cur_evt    (cur_evt),
    .pend_valid (pend_valid),
    .overflow   (overflow)
  );

  irq_log_writer #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .ENTRIES   (ENTRIES)
  ) u_writer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_valid (cur_valid),
    .cur_evt   (cur_evt),
    .mem_grant (mem_grant),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .log_ptr   (log_ptr),
    .slot_done (slot_done)
  );

  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_valid && !pend_valid) |-> !mem_we);

endmodule

// File: tb/test_irq_ring_logger.sv
`timescale 1ns/1ps
module test_irq_ring_logger;

  localparam int AW    = 15;
  localparam int BASE  = 'h0400;
  localparam int NENT  = 16;
  localparam int MAXW  = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evt_strobe = 1'b0;
  logic [15:0]   evt_id = '0;
  logic [15:0]   evt_cmd = '0;
  logic          mem_grant = 1'b1;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic [AW-1:0] log_ptr;
  logic          overflow;

  int n_chk = 0;
  int n_bad = 0;
  int n_wr  = 0;
  int rd    = 0;
  int cyc   = 0;
  int exp_ptr = BASE;
  int wr_addr [MAXW];
  int wr_data [MAXW];
  int wr_ptr  [MAXW];
  int wr_cyc  [MAXW];

  irq_ring_logger #(.ADDR_W(AW), .BASE_ADDR(BASE), .ENTRIES(NENT)) i_irq_ring_logger (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .evt_id(evt_id),
    .evt_cmd(evt_cmd), .mem_grant(mem_grant), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .log_ptr(log_ptr),
    .overflow(overflow)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // write monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (!mem_grant) begin
        n_chk++; n_bad++;
        $display("FAIL R5 write without grant act=1 exp=0");
      end
      if (n_wr < MAXW) begin
        wr_addr[n_wr] = int'(mem_addr);
        wr_data[n_wr] = int'(mem_wdata);
        wr_ptr[n_wr]  = int'(log_ptr);
        wr_cyc[n_wr]  = cyc;
        n_wr++;
      end
    end
  end

  task automatic check(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic int slot_after(int p);
    if (p == BASE + 2 * NENT - 2) return BASE;
    return p + 2;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic fire(int id, int cmd);
    evt_strobe = 1'b1; evt_id = 16'(id); evt_cmd = 16'(cmd);
    tick(1);
    evt_strobe = 1'b0;
  endtask

  // consume one expected entry from the write log
  task automatic expect_entry(string tag, int id, int cmd, bit back2back);
    if (n_wr < rd + 2) begin
      check({tag, " entry missing"}, n_wr, rd + 2);
    end else begin
      check({tag, " id addr"},  wr_addr[rd],   exp_ptr);
      check({tag, " id data"},  wr_data[rd],   id);
      check({tag, " cmd addr"}, wr_addr[rd+1], exp_ptr + 1);
      check({tag, " cmd data"}, wr_data[rd+1], cmd);
      check({tag, " R3 ptr during id"},  wr_ptr[rd],   exp_ptr);
      check({tag, " R3 ptr during cmd"}, wr_ptr[rd+1], exp_ptr);
      if (back2back) check({tag, " R2 consecutive"}, wr_cyc[rd+1], wr_cyc[rd] + 1);
    end
    rd += 2;
    exp_ptr = slot_after(exp_ptr);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    check("R1 ptr at base", int'(log_ptr), BASE);
    check("R1 no write", int'(mem_we), 0);
    check("R1 overflow clear", int'(overflow), 0);
    rst_n = 1'b1;
    exp_ptr = BASE;
    rd = n_wr;
    tick(1);
  endtask

  task automatic t_single();
    int start;
    start = cyc;
    fire('h1A01, 'h2B01);
    tick(1);
    check("R2 first write one cycle after strobe", n_wr, rd + 1);
    if (n_wr > rd) check("R2 first write cycle", wr_cyc[rd], start + 1);
    check("R3 ptr held mid-entry", int'(log_ptr), exp_ptr);
    tick(3);
    expect_entry("R2 single", 'h1A01, 'h2B01, 1);
    check("R3 ptr advanced by 2", int'(log_ptr), exp_ptr);
  endtask

  task automatic t_wrap();
    int p0;
    p0 = exp_ptr;
    for (int k = 0; k < NENT; k++) begin
      fire('h3000 + k, 'h4000 + k);
      tick(3);
      expect_entry("R4 ring", 'h3000 + k, 'h4000 + k, 1);
    end
    check("R4 full circle ptr", int'(log_ptr), p0);
    // advance to the top slot then check the wrap explicitly
    while (exp_ptr != BASE + 2 * NENT - 2) begin
      fire('h5000, 'h5001);
      tick(3);
      expect_entry("R4 fill", 'h5000, 'h5001, 1);
    end
    fire('h5100, 'h5101);
    tick(3);
    expect_entry("R4 top slot", 'h5100, 'h5101, 1);
    check("R4 wrap to base", int'(log_ptr), BASE);
    fire('h5200, 'h5201);
    tick(3);
    check("R4 overwrite oldest addr", n_wr > rd ? wr_addr[rd] : -1, BASE);
    expect_entry("R4 overwrite", 'h5200, 'h5201, 1);
  endtask

  task automatic t_stall();
    int w0;
    mem_grant = 1'b0;
    w0 = n_wr;
    fire('h6001, 'h6002);
    tick(5);
    check("R5 no write while grant low", n_wr, w0);
    check("R5 ptr frozen", int'(log_ptr), exp_ptr);
    mem_grant = 1'b1;
    tick(1);
    mem_grant = 1'b0;
    tick(4);
    check("R5 one word then stall", n_wr, w0 + 1);
    check("R5 ptr frozen mid-entry", int'(log_ptr), exp_ptr);
    mem_grant = 1'b1;
    tick(3);
    expect_entry("R5 resumed", 'h6001, 'h6002, 0);
    check("R5 ptr after resume", int'(log_ptr), exp_ptr);
  endtask

  task automatic t_overlap();
    fire('h7001, 'h7002);
    fire('h7101, 'h7102);
    tick(6);
    expect_entry("R6 first", 'h7001, 'h7002, 1);
    check("R6 held event follows at once", n_wr > rd ? wr_cyc[rd] : -1, wr_cyc[rd-1] + 1);
    expect_entry("R6 held", 'h7101, 'h7102, 1);
    check("R6 no overflow", int'(overflow), 0);
    check("R6 nothing extra", n_wr, rd);
  endtask

  task automatic t_done_cycle();
    fire('h8001, 'h8002);
    fire('h8101, 'h8102);
    fire('h8201, 'h8202);
    tick(8);
    check("R8 no overflow on completing-cycle strobe", int'(overflow), 0);
    expect_entry("R8 a", 'h8001, 'h8002, 1);
    expect_entry("R8 b", 'h8101, 'h8102, 1);
    expect_entry("R8 c", 'h8201, 'h8202, 1);
    check("R8 count", n_wr, rd);
  endtask

  task automatic t_overflow();
    int w0;
    mem_grant = 1'b0;
    w0 = n_wr;
    fire('h9001, 'h9002);
    fire('h9101, 'h9102);
    check("R7 no overflow yet", int'(overflow), 0);
    fire('h9201, 'h9202);
    check("R7 overflow raised", int'(overflow), 1);
    check("R7 nothing written while stalled", n_wr, w0);
    mem_grant = 1'b1;
    tick(8);
    expect_entry("R7 kept a", 'h9001, 'h9002, 1);
    expect_entry("R7 kept b", 'h9101, 'h9102, 1);
    check("R7 dropped event not written", n_wr, rd);
    fire('h9301, 'h9302);
    tick(4);
    expect_entry("R7 later", 'h9301, 'h9302, 1);
    check("R7 overflow sticky", int'(overflow), 1);
  endtask

  initial begin : watchdog
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    tick(1);
    do_reset();
    t_single();
    t_wrap();
    t_stall();
    t_overlap();
    t_done_cycle();
    t_overflow();
    do_reset();
    t_single();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule